// File: doc/BRIEF.md
# PCI Interrupt Status and Mask Unit

This block gathers the interrupt causes of a PCI host bridge into one place. Single-cycle event pulses from the inbound and outbound descriptor engines, an inbound out-of-descriptors pulse and a bus-abort pulse each set a sticky bit in a 32-bit status register. The external PCI INTA line is tracked as a level: its status bit is set on every cycle the line is high. Software clears status bits by writing ones to them.

A mask register with the same bit layout selects which status bits may raise the interrupt. A one-bit global enable then gates the result onto a single level interrupt line to the CPU. The three registers sit at byte offsets 0x500 (status), 0x504 (mask) and 0x508 (enable) of a simple synchronous register port. Writes take effect on the clock edge. Read data is combinational from the address and has no side effects.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, and whenever the active-low reset is held, the status, mask and enable registers all read 0 and `irq_out` is low.
- R2: A pulse on `in_desc_evt[k]` sets status bit k, and a pulse on `out_desc_evt[k]` sets status bit 4+k, for k = 0..3. The order of k is completed, ok, error, end-of-list. The bit is set on the clock edge that samples the pulse.
- R3: A pulse on `in_desc_empty` sets status bit 9, and a pulse on `bus_abort` sets status bit 26.
- R4: Status bit 25 is set on every edge at which `ext_inta` is high. A clear of bit 25 takes effect only on an edge at which the line is low.
- R5: A write to offset 0x500 clears each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged. Such a write never sets a bit.
- R6: When an event sets a status bit on the same edge as a write-one clear of that bit, the bit stays set.
- R7: The mask register at offset 0x504 stores only the implemented bit positions 0-7, 9, 25 and 26, so a write of all ones reads back as 0x060002FF.
- R8: Bit 0 of the enable register at offset 0x508 is the global enable. The other bits of that register read 0. While the enable is 0, `irq_out` is low.
- R9: `irq_out` is high exactly when the enable is 1 and some status bit is 1 where the same mask bit is 1. It follows a register change in the same cycle that the register takes its new value.
- R10: Unimplemented status bits always read 0. Reads of any offset other than the three registers return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_desc_evt | input | 4 | Inbound descriptor event pulses (completed, ok, error, end-of-list) |
| out_desc_evt | input | 4 | Outbound descriptor event pulses (completed, ok, error, end-of-list) |
| in_desc_empty | input | 1 | Inbound out-of-descriptors pulse |
| bus_abort | input | 1 | Bus abort pulse |
| ext_inta | input | 1 | External PCI INTA level, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_out | output | 1 | Level interrupt request to the CPU |

## Verification
The case that needs care is an event setting a status bit on the same edge that a software write-one clear targets that bit. Two instances are provoked. In the first, an inbound pulse coincides with a clear of that pulse's bit, while a neighbouring bit, pulsed in the same cycle, is set with no clear aimed at it. In the second, the external line is held high while software clears bit 25. In both the bit must read back as 1 afterwards, while bits in the same write that had no coinciding event must read 0. A clocked property also checks, on every edge, that a set is never lost to a clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned STAT_W    = 32;
  localparam int unsigned N_DESC_EV = 4;

  // status bit positions; software decodes these
  localparam int unsigned POS_IN_BASE  = 0;
  localparam int unsigned POS_OUT_BASE = 4;
  localparam int unsigned POS_IN_EMPTY = 9;
  localparam int unsigned POS_EXT      = 25;
  localparam int unsigned POS_ABORT    = 26;

  typedef logic [STAT_W-1:0] stat_t;

  // bits that hold state in status and mask
  function automatic stat_t impl_mask();
    stat_t m;
    m = '0;
    for (int k = 0; k < N_DESC_EV; k++) begin
      m[POS_IN_BASE + k]  = 1'b1;
      m[POS_OUT_BASE + k] = 1'b1;
    end
    m[POS_IN_EMPTY] = 1'b1;
    m[POS_EXT]      = 1'b1;
    m[POS_ABORT]    = 1'b1;
    return m;
  endfunction

  // next status: clears first, then sets win
  function automatic stat_t status_next(stat_t cur, stat_t set_v, stat_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // interrupt line level from registers
  function automatic logic irq_level(logic en, stat_t stat, stat_t mask);
    return en & (|(stat & mask));
  endfunction

endpackage

// File: rtl/irq_evt_map.sv
module irq_evt_map
  import irq_pkg::*;
(
  input  logic [N_DESC_EV-1:0] in_evt,
  input  logic [N_DESC_EV-1:0] out_evt,
  input  logic                 in_empty,
  input  logic                 abort_evt,
  input  logic                 ext_line,
  output stat_t                set_vec
);

  stat_t desc_vec;

  // descriptor chains map to two contiguous groups
  for (genvar g = 0; g < STAT_W; g++) begin : g_desc
    if (g >= POS_IN_BASE && g < POS_IN_BASE + N_DESC_EV) begin : g_in
      assign desc_vec[g] = in_evt[g - POS_IN_BASE];
    end else if (g >= POS_OUT_BASE && g < POS_OUT_BASE + N_DESC_EV) begin : g_out
      assign desc_vec[g] = out_evt[g - POS_OUT_BASE];
    end else begin : g_none
      assign desc_vec[g] = 1'b0;
    end
  end

  always_comb begin
    set_vec               = desc_vec;
    set_vec[POS_IN_EMPTY] = in_empty;
    set_vec[POS_EXT]      = ext_line;
    set_vec[POS_ABORT]    = abort_evt;
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_vec,
  input  stat_t clr_vec,
  output stat_t stat_q
);

  localparam stat_t IMPL = impl_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= status_next(stat_q, set_vec, clr_vec) & IMPL;
    end
  end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'h500,
  parameter logic [ADDR_W-1:0] OFS_MASK = 12'h504,
  parameter logic [ADDR_W-1:0] OFS_EN   = 12'h508
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  stat_t             wdata,
  input  stat_t             stat_q,
  output stat_t             clr_vec,
  output stat_t             mask_q,
  output logic              en_q,
  output stat_t             rdata
);

  localparam stat_t IMPL = impl_mask();

  logic hit_stat, hit_mask, hit_en;

  assign hit_stat = (addr == OFS_STAT);
  assign hit_mask = (addr == OFS_MASK);
  assign hit_en   = (addr == OFS_EN);

  assign clr_vec = (we && hit_stat) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (we && hit_mask) mask_q <= wdata & IMPL;
      if (we && hit_en)   en_q   <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_stat)      rdata = stat_q;
    else if (hit_mask) rdata = mask_q;
    else if (hit_en)   rdata[0] = en_q;
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'h500,
  parameter logic [ADDR_W-1:0] OFS_MASK = 12'h504,
  parameter logic [ADDR_W-1:0] OFS_EN   = 12'h508
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_DESC_EV-1:0] in_desc_evt,
  input  logic [N_DESC_EV-1:0] out_desc_evt,
  input  logic                 in_desc_empty,
  input  logic                 bus_abort,
  input  logic                 ext_inta,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [STAT_W-1:0]    reg_wdata,
  output logic [STAT_W-1:0]    reg_rdata,
  output logic                 irq_out
);

  // named internal events, observed by the checker
  stat_t set_vec;
  stat_t clr_vec;
  stat_t stat_q;
  stat_t mask_q;
  logic  en_q;

  irq_evt_map u_map (
    .in_evt    (in_desc_evt),
    .out_evt   (out_desc_evt),
    .in_empty  (in_desc_empty),
    .abort_evt (bus_abort),
    .ext_line  (ext_inta),
    .set_vec   (set_vec)
  );

  irq_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  irq_reg_port #(
    .ADDR_W   (ADDR_W),
    .OFS_STAT (OFS_STAT),
    .OFS_MASK (OFS_MASK),
    .OFS_EN   (OFS_EN)
  ) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .stat_q  (stat_q),
    .clr_vec (clr_vec),
    .mask_q  (mask_q),
    .en_q    (en_q),
    .rdata   (reg_rdata)
  );

  assign irq_out = irq_level(en_q, stat_q, mask_q);

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input stat_t set_vec,
  input stat_t clr_vec,
  input stat_t stat,
  input stat_t mask,
  input logic  en,
  input logic  ext_line,
  input logic  irq
);

  localparam stat_t IMPL = impl_mask();

  // R1: registers come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat == '0 && mask == '0 && !en));

  // R2, R3, R6: every requested set lands, even against a clear
  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));

  // R4: a high external line leaves bit 25 set
  p_ext_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_line |=> stat[POS_EXT]);

  // R5: a cleared bit with no event reads 0 afterwards
  p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((stat & $past(clr_vec) & ~$past(set_vec)) == '0));

  // R5, R10: no bit rises without an event
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(set_vec)) == '0));

  // R7, R10: unimplemented positions never hold a 1
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat | mask) & ~IMPL) == '0);

  // R8: global enable gates the line
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  // R9: a raised line has a masked cause
  p_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat & mask) != '0));

endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .stat     (stat_q),
  .mask     (mask_q),
  .en       (en_q),
  .ext_line (ext_inta),
  .irq      (irq_out)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;

  localparam logic [11:0] A_STAT = 12'h500;
  localparam logic [11:0] A_MASK = 12'h504;
  localparam logic [11:0] A_EN   = 12'h508;
  localparam logic [11:0] A_NONE = 12'h50C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_e = '0;
  logic [3:0]  out_e = '0;
  logic        empty = 1'b0;
  logic        abt = 1'b0;
  logic        ext = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = A_STAT;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_desc_evt   (in_e),
    .out_desc_evt  (out_e),
    .in_desc_empty (empty),
    .bus_abort     (abt),
    .ext_inta      (ext),
    .reg_we        (we),
    .reg_addr      (addr),
    .reg_wdata     (wd),
    .reg_rdata     (rd),
    .irq_out       (irq)
  );

  typedef struct packed {
    logic [3:0]  in_e;
    logic [3:0]  out_e;
    logic        empty;
    logic        abt;
    logic        ext;
    logic        we;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h00000001, 8'd2}, // R2 inbound completed
    '{4'h0, 4'h8, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h00000081, 8'd2}, // R2 outbound end-of-list
    '{4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        32'h00000281, 8'd3}, // R3 out-of-descriptors
    '{4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,        32'h04000281, 8'd3}, // R3 abort
    '{4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000001, 32'h04000280, 8'd5}, // R5 single clear
    '{4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        32'h06000280, 8'd4}, // R4 line high
    '{4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h02000000, 32'h06000280, 8'd4}, // R4 clear while high
    '{4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h06000280, 32'h00000000, 8'd5}, // R5 clear several
    '{4'h6, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000002, 32'h00000006, 8'd6}, // R6 set beats clear
    '{4'h0, 4'h4, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000040, 8'd6}, // R6 clear all, one set
    '{4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00000000, 32'h00000040, 8'd5}  // R5 zeros no effect
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd;
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wd = d;
    @(posedge clk);
    #1;
    we = 1'b0; wd = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    reg_read(A_STAT, v); check("R1 status at reset", v, 32'h0);
    reg_read(A_MASK, v); check("R1 mask at reset", v, 32'h0);
    reg_read(A_EN, v);   check("R1 enable at reset", v, 32'h0);
    check("R1 irq at reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_e = VECS[i].in_e; out_e = VECS[i].out_e;
      empty = VECS[i].empty; abt = VECS[i].abt; ext = VECS[i].ext;
      we = VECS[i].we; wd = VECS[i].wd; addr = A_STAT;
      @(posedge clk);
      #1;
      in_e = '0; out_e = '0; empty = 1'b0; abt = 1'b0; we = 1'b0; wd = '0;
      reg_read(A_STAT, v);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
    end

    // R7 mask stores implemented bits only
    reg_write(A_MASK, 32'hFFFFFFFF);
    reg_read(A_MASK, v); check("R7 mask readback", v, 32'h060002FF);
    check("R8 irq low while disabled", {31'b0, irq}, 32'h0);
    // R8 enable bit 0 only
    reg_write(A_EN, 32'hFFFFFFFF);
    reg_read(A_EN, v); check("R8 enable readback", v, 32'h1);
    check("R9 irq with masked cause", {31'b0, irq}, 32'h1);
    reg_write(A_EN, 32'h0);
    check("R8 irq gated off", {31'b0, irq}, 32'h0);
    reg_write(A_EN, 32'h1);
    reg_write(A_MASK, 32'h00000001);
    check("R9 irq low with cause unmasked", {31'b0, irq}, 32'h0);
    @(negedge clk);
    in_e = 4'h1;
    @(posedge clk);
    #1;
    in_e = '0;
    check("R9 irq rises with bit 0", {31'b0, irq}, 32'h1);

    // R10 unmapped offset
    reg_read(A_NONE, v); check("R10 unmapped read", v, 32'h0);
    reg_write(A_NONE, 32'hFFFFFFFF);
    reg_read(A_MASK, v); check("R10 mask untouched", v, 32'h00000001);
    reg_read(A_EN, v);   check("R10 enable untouched", v, 32'h1);
    reg_read(A_STAT, v); check("R10 status untouched", v, 32'h00000041);

    // R5 clear everything
    reg_write(A_STAT, 32'hFFFFFFFF);
    reg_read(A_STAT, v); check("R5 full clear", v, 32'h0);
    check("R9 irq falls after clear", {31'b0, irq}, 32'h0);

    // R10 all sources at once: only implemented bits
    @(negedge clk);
    in_e = 4'hF; out_e = 4'hF; empty = 1'b1; abt = 1'b1; ext = 1'b1;
    @(posedge clk);
    #1;
    in_e = '0; out_e = '0; empty = 1'b0; abt = 1'b0; ext = 1'b0;
    reg_read(A_STAT, v); check("R10 all sources", v, 32'h060002FF);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    reg_read(A_STAT, v); check("R1 status after reset", v, 32'h0);
    reg_read(A_MASK, v); check("R1 mask after reset", v, 32'h0);
    reg_read(A_EN, v);   check("R1 enable after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule